// File: doc/BRIEF.md
# Variable-Page TLB Lookup Engine

This block is the lookup half of a fully associative translation buffer for a 32-bit soft processor. Every entry is compared against the incoming virtual address in parallel. Each entry carries its own page size, from 1 KiB to 16 MiB in steps of four. An entry can also be tied to one process through an 8-bit translation ID. A zone selector in each entry lets a global zone protection register override the entry's write and execute bits, depending on the privilege level.

The entry contents come in as flat port vectors, which the register block that owns the entries drives. A request is a virtual address, an access kind, a user flag, the current process ID and the zone register, marked by a request strobe. One clock later the block returns hit, the index of the winning entry, the physical address, the read/write/execute permissions and a fault flag for the requested kind. Between requests the result stays as it was.

Top module: `tlb_lookup`

## Requirements
- R1: The tag word holds the page number in bits 31:10, a size code in bits 9:7 and the valid flag in bit 6. Size codes 0 to 7 give pages of 1 KiB, 4 KiB, 16 KiB, 64 KiB, 256 KiB, 1 MiB, 4 MiB and 16 MiB.
- R2: An entry matches only when its valid flag is set and the virtual address agrees with the tag word on every bit at or above the page size. Bits below the page size are ignored.
- R3: An entry with translation ID 0 matches any process. An entry with a nonzero ID matches only when the ID equals the process ID input.
- R4: When several entries match, the entry with the lowest index is reported.
- R5: The data word holds the real page number in bits 31:10, execute-enable in bit 9, write-enable in bit 8 and the zone number in bits 7:4. The physical address takes the data word's bits at or above the page size and the virtual address bits below it.
- R6: The zone field for zone z is bits 31-2z down to 30-2z of the zone register. Zone 0 therefore sits in bits 31:30.
- R7: A zone number above NUM_ZONES (default 12) is treated as field value 1. With ZONES_EN cleared, every zone is treated as field value 1.
- R8: Field 0 denies read, write and execute in user mode. Field 3 grants write and execute in supervisor mode. In every other case, write and execute follow the entry bits and read is granted.
- R9: The access kind is encoded 0 = read, 1 = write, 2 = fetch, and 3 is handled as read. The fault flag is set on a hit whose requested permission is not granted. A miss reports hit 0, index 0, address 0, all permissions 0 and no fault.
- R10: The result and res_valid_o appear on the clock edge after a request. Without a request, res_valid_o is 0 on the next edge and the other outputs keep their values.
- R11: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Lookup request strobe |
| vaddr_i | input | 32 | Virtual address |
| kind_i | input | 2 | Access kind (0 read, 1 write, 2 fetch) |
| user_i | input | 1 | 1 = user mode, 0 = supervisor |
| pid_i | input | 8 | Current process ID |
| zpr_i | input | 32 | Zone protection register |
| tag_words_i | input | NUM_ENTRIES*32 | Tag words, entry i at bits 32i+31:32i |
| data_words_i | input | NUM_ENTRIES*32 | Data words, same packing |
| tids_i | input | NUM_ENTRIES*8 | Translation IDs, entry i at bits 8i+7:8i |
| res_valid_o | output | 1 | Result valid for one cycle |
| hit_o | output | 1 | Some entry matched |
| idx_o | output | log2(NUM_ENTRIES) | Winning entry index |
| paddr_o | output | 32 | Physical address |
| perm_r_o | output | 1 | Read permitted |
| perm_w_o | output | 1 | Write permitted |
| perm_x_o | output | 1 | Execute permitted |
| fault_o | output | 1 | Requested access not permitted on a hit |

## Verification
The assertions assume that the entry vectors, the zone register and the process ID do not change in the cycle a request is sampled. They assume nothing about how entries overlap, because overlap is resolved by index. The bench changes entry contents only while no request is in flight, at the falling edge, and it holds every request input for exactly one rising edge. Each scenario places pages at aligned bases, so the expected addresses follow directly from the size table.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int WORD_W   = 32;
  localparam int TID_W    = 8;
  localparam int PAGE_LSB = 10;

  localparam int SZ_HI    = 9;
  localparam int SZ_LO    = 7;
  localparam int VALID_B  = 6;

  localparam int EX_B     = 9;
  localparam int WR_B     = 8;
  localparam int ZONE_HI  = 7;
  localparam int ZONE_LO  = 4;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } perm_t;

  // keep-mask for a page of 4^code KiB
  function automatic logic [WORD_W-1:0] page_mask(input logic [2:0] code);
    logic [4:0] sh;
    sh = 5'd10 + {1'b0, code, 1'b0};
    return ~((32'd1 << sh) - 32'd1);
  endfunction
endpackage

// File: rtl/tlb_entry_match.sv
module tlb_entry_match
  import tlb_pkg::*;
(
  input  logic [WORD_W-1:0] tag_i,
  input  logic [TID_W-1:0]  tid_i,
  input  logic [WORD_W-1:0] vaddr_i,
  input  logic [TID_W-1:0]  pid_i,
  output logic              match_o
);
  logic [WORD_W-1:0] keep;
  logic              page_eq;
  logic              pid_ok;

  always_comb begin
    keep    = page_mask(tag_i[SZ_HI:SZ_LO]);
    page_eq = ((vaddr_i ^ tag_i) & keep & 32'hFFFF_FC00) == '0;
    pid_ok  = (tid_i == '0) || (tid_i == pid_i);
    match_o = tag_i[VALID_B] && page_eq && pid_ok;
  end
endmodule

// File: rtl/tlb_prio_pick.sv
module tlb_prio_pick #(
  parameter int N    = 64,
  parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    match_i,
  output logic            any_o,
  output logic [IDXW-1:0] idx_o
);
  always_comb begin
    any_o = |match_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = IDXW'(i);
    end
  end
endmodule

// File: rtl/tlb_perm_eval.sv
module tlb_perm_eval
  import tlb_pkg::*;
#(
  parameter int NUM_ZONES = 12,
  parameter bit ZONES_EN  = 1'b1
) (
  input  logic [WORD_W-1:0] data_i,
  input  logic [WORD_W-1:0] zpr_i,
  input  logic              user_i,
  input  logic [1:0]        kind_i,
  output perm_t             perm_o,
  output logic              deny_o
);
  localparam logic [3:0] ZMAX = 4'(NUM_ZONES);

  logic [3:0]        zone;
  logic [4:0]        shamt;
  logic [WORD_W-1:0] zsh;
  logic [1:0]        zfield;

  always_comb begin
    zone  = data_i[ZONE_HI:ZONE_LO];
    shamt = 5'd30 - {zone, 1'b0};
    zsh   = zpr_i >> shamt;
    if (!ZONES_EN || (zone > ZMAX)) zfield = 2'b01;
    else                            zfield = zsh[1:0];

    perm_o.r = 1'b1;
    perm_o.w = data_i[WR_B];
    perm_o.x = data_i[EX_B];
    case (zfield)
      2'b00: if (user_i) begin
        perm_o.r = 1'b0;
        perm_o.w = 1'b0;
        perm_o.x = 1'b0;
      end
      2'b11: if (!user_i) begin
        perm_o.w = 1'b1;
        perm_o.x = 1'b1;
      end
      default: ;
    endcase

    case (acc_kind_e'(kind_i))
      ACC_WRITE: deny_o = !perm_o.w;
      ACC_FETCH: deny_o = !perm_o.x;
      default:   deny_o = !perm_o.r;
    endcase
  end
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int NUM_ZONES   = 12,
  parameter bit ZONES_EN    = 1'b1,
  localparam int IDXW       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid_i,
  input  logic [31:0]               vaddr_i,
  input  logic [1:0]                kind_i,
  input  logic                      user_i,
  input  logic [7:0]                pid_i,
  input  logic [31:0]               zpr_i,
  input  logic [NUM_ENTRIES*32-1:0] tag_words_i,
  input  logic [NUM_ENTRIES*32-1:0] data_words_i,
  input  logic [NUM_ENTRIES*8-1:0]  tids_i,
  output logic                      res_valid_o,
  output logic                      hit_o,
  output logic [IDXW-1:0]           idx_o,
  output logic [31:0]               paddr_o,
  output logic                      perm_r_o,
  output logic                      perm_w_o,
  output logic                      perm_x_o,
  output logic                      fault_o
);
  logic [NUM_ENTRIES-1:0] match;
  logic                   any_hit;
  logic [IDXW-1:0]        win_idx;
  logic [WORD_W-1:0]      sel_tag;
  logic [WORD_W-1:0]      sel_data;
  logic [WORD_W-1:0]      keep;
  perm_t                  perm;
  logic                   deny;

  logic              hit_d, fault_d;
  logic [IDXW-1:0]   idx_d;
  logic [WORD_W-1:0] pa_d;
  perm_t             perm_d;

  logic              vld_q, hit_q, fault_q;
  logic [IDXW-1:0]   idx_q;
  logic [WORD_W-1:0] pa_q;
  perm_t             perm_q;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    tlb_entry_match u_match (
      .tag_i   (tag_words_i[g*32 +: 32]),
      .tid_i   (tids_i[g*8 +: 8]),
      .vaddr_i (vaddr_i),
      .pid_i   (pid_i),
      .match_o (match[g])
    );
  end

  tlb_prio_pick #(.N(NUM_ENTRIES), .IDXW(IDXW)) u_pick (
    .match_i (match),
    .any_o   (any_hit),
    .idx_o   (win_idx)
  );

  always_comb begin
    sel_tag  = tag_words_i[win_idx*32 +: 32];
    sel_data = data_words_i[win_idx*32 +: 32];
    keep     = page_mask(sel_tag[SZ_HI:SZ_LO]);
  end

  tlb_perm_eval #(.NUM_ZONES(NUM_ZONES), .ZONES_EN(ZONES_EN)) u_perm (
    .data_i (sel_data),
    .zpr_i  (zpr_i),
    .user_i (user_i),
    .kind_i (kind_i),
    .perm_o (perm),
    .deny_o (deny)
  );

  // next-state
  always_comb begin
    hit_d   = any_hit;
    idx_d   = any_hit ? win_idx : '0;
    pa_d    = any_hit ? ((sel_data & keep & 32'hFFFF_FC00) | (vaddr_i & ~keep)) : '0;
    perm_d  = any_hit ? perm : '0;
    fault_d = any_hit && deny;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      hit_q   <= 1'b0;
      idx_q   <= '0;
      pa_q    <= '0;
      perm_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      vld_q <= req_valid_i;
      if (req_valid_i) begin
        hit_q   <= hit_d;
        idx_q   <= idx_d;
        pa_q    <= pa_d;
        perm_q  <= perm_d;
        fault_q <= fault_d;
      end
    end
  end

  assign res_valid_o = vld_q;
  assign hit_o       = hit_q;
  assign idx_o       = idx_q;
  assign paddr_o     = pa_q;
  assign perm_r_o    = perm_q.r;
  assign perm_w_o    = perm_q.w;
  assign perm_x_o    = perm_q.x;
  assign fault_o     = fault_q;
endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid_i,
  input logic [31:0] vaddr_i,
  input logic        res_valid_o,
  input logic        hit_o,
  input logic [31:0] paddr_o,
  input logic        perm_r_o,
  input logic        perm_w_o,
  input logic        perm_x_o,
  input logic        fault_o
);
  // R10
  res_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> res_valid_o);

  // R10
  res_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> (!res_valid_o && $stable(hit_o) && $stable(paddr_o) && $stable(fault_o)));

  // R9
  fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> hit_o);

  // R9
  miss_no_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (!perm_r_o && !perm_w_o && !perm_x_o && paddr_o == 32'd0));

  // R5
  offset_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && hit_o) |-> (paddr_o[9:0] == $past(vaddr_i[9:0])));

  // R8
  write_implies_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_w_o || perm_x_o) |-> perm_r_o);
endmodule

bind tlb_lookup tlb_lookup_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid_i (req_valid_i),
  .vaddr_i     (vaddr_i),
  .res_valid_o (res_valid_o),
  .hit_o       (hit_o),
  .paddr_o     (paddr_o),
  .perm_r_o    (perm_r_o),
  .perm_w_o    (perm_w_o),
  .perm_x_o    (perm_x_o),
  .fault_o     (fault_o)
);

// File: tb/tb_tlb_lookup.sv
`timescale 1ns/1ps
module tb_tlb_lookup;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [31:0] vaddr;
  logic [1:0]  kind;
  logic        user;
  logic [7:0]  pid;
  logic [31:0] zpr;
  logic [31:0] tagw  [N];
  logic [31:0] dataw [N];
  logic [7:0]  tidw  [N];
  logic [N*32-1:0] tag_flat, data_flat;
  logic [N*8-1:0]  tid_flat;

  logic        res_valid, hit, pr, pw, px, fault;
  logic [5:0]  idx;
  logic [31:0] paddr;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      tag_flat[i*32 +: 32]  = tagw[i];
      data_flat[i*32 +: 32] = dataw[i];
      tid_flat[i*8 +: 8]    = tidw[i];
    end
  end

  tlb_lookup dut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .vaddr_i(vaddr),
    .kind_i(kind), .user_i(user), .pid_i(pid), .zpr_i(zpr),
    .tag_words_i(tag_flat), .data_words_i(data_flat), .tids_i(tid_flat),
    .res_valid_o(res_valid), .hit_o(hit), .idx_o(idx), .paddr_o(paddr),
    .perm_r_o(pr), .perm_w_o(pw), .perm_x_o(px), .fault_o(fault)
  );

  function automatic logic [31:0] mk_tag(logic [31:0] epn, logic [2:0] sz, logic v);
    return (epn & 32'hFFFF_FC00) | {22'd0, sz, v, 6'd0};
  endfunction

  function automatic logic [31:0] mk_data(logic [31:0] rpn, logic ex, logic wr, logic [3:0] z);
    return (rpn & 32'hFFFF_FC00) | {22'd0, ex, wr, z, 4'd0};
  endfunction

  function automatic logic [31:0] zset(int z, logic [1:0] f);
    logic [31:0] base;
    base = 32'h5555_5555;
    base[31-2*z -: 2] = f;
    return base;
  endfunction

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      tagw[i] = '0; dataw[i] = '0; tidw[i] = '0;
    end
  endtask

  task automatic lookup(logic [31:0] va, logic [1:0] k, logic u, logic [7:0] p);
    @(negedge clk);
    vaddr = va; kind = k; user = u; pid = p; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check(string rq, logic eh, logic [5:0] ei, logic [31:0] ea,
                       logic er, logic ew, logic ex, logic ef);
    total++;
    if (res_valid !== 1'b1 || hit !== eh || idx !== ei || paddr !== ea ||
        pr !== er || pw !== ew || px !== ex || fault !== ef) begin
      bad++;
      $display("FAIL %s: got v=%b h=%b i=%0d pa=%h rwx=%b%b%b f=%b exp v=1 h=%b i=%0d pa=%h rwx=%b%b%b f=%b",
               rq, res_valid, hit, idx, paddr, pr, pw, px, fault, eh, ei, ea, er, ew, ex, ef);
    end
  endtask

  task automatic t_reset();
    total++;
    if (res_valid !== 0 || hit !== 0 || idx !== 0 || paddr !== 0 ||
        pr !== 0 || pw !== 0 || px !== 0 || fault !== 0) begin
      bad++;
      $display("FAIL R11: got v=%b h=%b i=%0d pa=%h exp all zero", res_valid, hit, idx, paddr);
    end
  endtask

  // R1 R2 R5: every size code, inside and just past the page
  task automatic t_sizes();
    logic [31:0] sz, msk, exp_pa;
    for (int c = 0; c < 8; c++) begin
      clear_all();
      sz  = 32'd1 << (10 + 2*c);
      msk = ~(sz - 1);
      tagw[5]  = mk_tag(32'h4000_0000, 3'(c), 1'b1);
      dataw[5] = mk_data(32'h80FF_FC00, 1'b0, 1'b1, 4'd1);
      exp_pa = (32'h80FF_FC00 & msk) | (sz - 1);
      lookup(32'h4000_0000 + sz - 1, 2'd0, 1'b1, 8'h01);
      check("R1 inside page", 1, 6'd5, exp_pa, 1, 1, 0, 0);
      lookup(32'h4000_0000 + sz, 2'd0, 1'b1, 8'h01);
      check("R2 past page", 0, 0, 0, 0, 0, 0, 0);
    end
  endtask

  // R2: invalid entry never matches
  task automatic t_valid();
    clear_all();
    tagw[7]  = mk_tag(32'h1234_0000, 3'd2, 1'b0);
    dataw[7] = mk_data(32'h0A00_0000, 1'b1, 1'b1, 4'd1);
    lookup(32'h1234_0010, 2'd0, 1'b0, 8'h00);
    check("R2 invalid entry", 0, 0, 0, 0, 0, 0, 0);
  endtask

  // R3: translation ID filter
  task automatic t_tid();
    clear_all();
    tagw[9]  = mk_tag(32'h2000_0000, 3'd1, 1'b1);
    dataw[9] = mk_data(32'h3000_0000, 1'b1, 1'b0, 4'd1);
    tidw[9]  = 8'h33;
    lookup(32'h2000_0123, 2'd0, 1'b1, 8'h33);
    check("R3 tid equal", 1, 6'd9, 32'h3000_0123, 1, 0, 1, 0);
    lookup(32'h2000_0123, 2'd0, 1'b1, 8'h34);
    check("R3 tid differs", 0, 0, 0, 0, 0, 0, 0);
    tidw[9] = 8'h00;
    lookup(32'h2000_0123, 2'd0, 1'b1, 8'h99);
    check("R3 tid zero global", 1, 6'd9, 32'h3000_0123, 1, 0, 1, 0);
  endtask

  // R4: lowest index wins
  task automatic t_prio();
    clear_all();
    tagw[10]  = mk_tag(32'h5000_0000, 3'd3, 1'b1);
    dataw[10] = mk_data(32'h6100_0000, 1'b0, 0, 4'd1);
    tagw[3]   = mk_tag(32'h5000_0000, 3'd5, 1'b1);
    dataw[3]  = mk_data(32'h6200_0000, 1'b0, 0, 4'd1);
    tagw[63]  = mk_tag(32'h5000_0000, 3'd0, 1'b1);
    dataw[63] = mk_data(32'h6300_0000, 1'b0, 0, 4'd1);
    lookup(32'h5000_0044, 2'd0, 1'b1, 8'h00);
    check("R4 lowest of three", 1, 6'd3, 32'h6200_0044, 1, 0, 0, 0);
    tagw[3] = '0;
    lookup(32'h5000_0044, 2'd0, 1'b1, 8'h00);
    check("R4 next lowest", 1, 6'd10, 32'h6100_0044, 1, 0, 0, 0);
    tagw[10] = '0;
    lookup(32'h5000_0044, 2'd0, 1'b1, 8'h00);
    check("R4 last index", 1, 6'd63, 32'h6300_0044, 1, 0, 0, 0);
  endtask

  // R6 R7 R8: zone overrides
  task automatic t_zones();
    clear_all();
    tagw[2]  = mk_tag(32'h7000_0000, 3'd0, 1'b1);
    dataw[2] = mk_data(32'h0800_0000, 1'b0, 1'b0, 4'd4);
    zpr = zset(4, 2'b11);
    lookup(32'h7000_0001, 2'd1, 1'b0, 8'h00);
    check("R8 zone3 supervisor", 1, 6'd2, 32'h0800_0001, 1, 1, 1, 0);
    lookup(32'h7000_0001, 2'd1, 1'b1, 8'h00);
    check("R8 zone3 user", 1, 6'd2, 32'h0800_0001, 1, 0, 0, 1);
    zpr = zset(4, 2'b00);
    lookup(32'h7000_0001, 2'd0, 1'b1, 8'h00);
    check("R8 zone0 user", 1, 6'd2, 32'h0800_0001, 0, 0, 0, 1);
    lookup(32'h7000_0001, 2'd0, 1'b0, 8'h00);
    check("R8 zone0 supervisor", 1, 6'd2, 32'h0800_0001, 1, 0, 0, 0);
    zpr = zset(4, 2'b10) | 32'h0000_0000;
    lookup(32'h7000_0001, 2'd2, 1'b0, 8'h00);
    check("R8 zone2 entry bits", 1, 6'd2, 32'h0800_0001, 1, 0, 0, 1);
    // R6: field for zone 4 must come from bits 23:22 only
    zpr = 32'hFFFF_FFFF & ~(32'h3 << 22);
    lookup(32'h7000_0001, 2'd0, 1'b1, 8'h00);
    check("R6 zone field position", 1, 6'd2, 32'h0800_0001, 0, 0, 0, 1);
    // R7: zone 12 in range, zone 13 out of range
    dataw[2] = mk_data(32'h0800_0000, 1'b0, 1'b1, 4'd12);
    zpr = 32'h0;
    lookup(32'h7000_0002, 2'd1, 1'b1, 8'h00);
    check("R7 zone12 in range", 1, 6'd2, 32'h0800_0002, 0, 0, 0, 1);
    dataw[2] = mk_data(32'h0800_0000, 1'b0, 1'b1, 4'd13);
    lookup(32'h7000_0002, 2'd1, 1'b1, 8'h00);
    check("R7 zone13 out of range", 1, 6'd2, 32'h0800_0002, 1, 1, 0, 0);
    zpr = 32'h5555_5555;
  endtask

  // R9: fault per access kind
  task automatic t_kinds();
    clear_all();
    tagw[0]  = mk_tag(32'h9000_0000, 3'd1, 1'b1);
    dataw[0] = mk_data(32'hA000_0000, 1'b0, 1'b1, 4'd1);
    lookup(32'h9000_0FFF, 2'd1, 1'b1, 8'h00);
    check("R9 write allowed", 1, 0, 32'hA000_0FFF, 1, 1, 0, 0);
    lookup(32'h9000_0FFF, 2'd2, 1'b1, 8'h00);
    check("R9 fetch denied", 1, 0, 32'hA000_0FFF, 1, 1, 0, 1);
    lookup(32'h9000_0FFF, 2'd3, 1'b1, 8'h00);
    check("R9 kind3 as read", 1, 0, 32'hA000_0FFF, 1, 1, 0, 0);
    lookup(32'hB000_0000, 2'd2, 1'b1, 8'h00);
    check("R9 miss no fault", 0, 0, 0, 0, 0, 0, 0);
  endtask

  // R10: outputs held without a request
  task automatic t_hold();
    clear_all();
    tagw[4]  = mk_tag(32'hC000_0000, 3'd2, 1'b1);
    dataw[4] = mk_data(32'hD000_0000, 1'b1, 1'b1, 4'd1);
    lookup(32'hC000_1234, 2'd0, 1'b0, 8'h00);
    check("R10 one-cycle result", 1, 6'd4, 32'hD000_1234, 1, 1, 1, 0);
    @(negedge clk);
    vaddr = 32'h0000_0000;
    tagw[4] = '0;
    @(negedge clk);
    total++;
    if (res_valid !== 0 || hit !== 1 || idx !== 4 || paddr !== 32'hD000_1234) begin
      bad++;
      $display("FAIL R10 hold: got v=%b h=%b i=%0d pa=%h exp v=0 h=1 i=4 pa=d0001234",
               res_valid, hit, idx, paddr);
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; vaddr = '0; kind = '0; user = 1'b0;
    pid = '0; zpr = 32'h5555_5555;
    clear_all();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_sizes();
    t_valid();
    t_tid();
    t_prio();
    t_zones();
    t_kinds();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule